// File: doc/BRIEF.md
# Fast Link Pulse Burst Transmitter

This block turns a 16-bit link code word into a fast-link-pulse burst on a single output line that feeds an external line driver. A burst has 33 positions. The even positions, counted from zero, always carry a clock pulse. Each odd position carries one code-word bit: a pulse for 1, no pulse for 0. The bits go out least significant first. By convention the caller puts the selector value 00001 in bits [4:0] and its advertised abilities in bits [15:5]. The block sends the word exactly as it is given.

A `start` strobe arms the block, and bursts then repeat without further action. A `stop` strobe disarms it. A burst already on the line always completes, and a stop that arrives during the inter-burst gap returns the block to idle on the next tick. All timing counts ticks of the `tick` clock enable. The parameters are `PULSE_TICKS` (pulse width), `HALF_TICKS` (spacing from one position to the next), `GAP_TICKS` (quiet time after a burst) and `N_BITS`. With a 100 ns tick, the defaults give a 100 ns pulse, 62.5 us position spacing (125 us between clock pulses) and a burst period of about 16 ms.

The controller has four states: `ST_IDLE`, `ST_MARK` (the pulse window of a position), `ST_SPACE` (the rest of the position) and `ST_GAP`. Every transition happens only in a cycle where `tick` is high:
- IDLE to MARK when armed. This latches the word and selects position 0.
- MARK to SPACE when the pulse window expires.
- SPACE to MARK when the position expires and it is not the last one. This advances to the next position.
- SPACE to GAP when the last position expires while armed. This raises the done flag.
- SPACE to IDLE when the last position expires while disarmed. This also raises the done flag.
- GAP to MARK when the gap expires while armed. This latches a new word.
- GAP to IDLE when disarmed.

Top module: `flp_burst_tx`

## Requirements
- R1: After reset, `pulse_out` and `burst_done` are low, and both stay low until a start strobe has been seen.
- R2: Every burst contains the 17 clock pulses, at positions 0, 2, 4, … 32.
- R3: Position 2k+1 carries code-word bit k, least significant bit first: high during its pulse window if the bit is 1, low throughout if it is 0. A burst therefore holds 17 + popcount(word) pulses.
- R4: Each pulse is high for exactly `PULSE_TICKS` ticks. Consecutive positions begin `HALF_TICKS` ticks apart. The first pulse begins on the first tick cycle after the block is armed.
- R5: `burst_done` is high for exactly one cycle, the cycle after the last position's `HALF_TICKS` window ends.
- R6: While armed, the next burst's first pulse begins `GAP_TICKS` ticks after the done strobe. The burst period is therefore 33·`HALF_TICKS` + `GAP_TICKS` ticks.
- R7: The code word is sampled only when a burst begins. A change to `code_word` during a burst has no effect on that burst.
- R8: After a stop strobe, the burst in progress completes and no later burst starts. A stop during the gap returns the block to idle on the next tick, with no pulse.
- R9: A start and a stop in the same cycle leave the block disarmed.
- R10: In cycles where `tick` is low, the state and timing do not advance, and the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that paces all timing |
| start | input | 1 | One-cycle strobe that arms repeated bursts |
| stop | input | 1 | One-cycle strobe that disarms; takes priority over start |
| code_word | input | N_BITS | Link code word; bit 0 is sent first |
| pulse_out | output | 1 | Pulse line to the line driver |
| burst_done | output | 1 | One-cycle flag at the end of each burst |

## Verification
A wrong slot index or a corrupted shift register shows up as a pulse that appears or vanishes in a data position, within one position time (`HALF_TICKS` ticks). A wrong tick count stretches or shortens a pulse within a single pulse width. A run flag or state that fails to return to idle shows up as an extra burst one gap later. A bench model that steps tick by tick and is compared on every clock catches each of these in the first cycle the line differs. A per-burst pulse count and a check of the interval between done strobes confirm the aggregate content and the burst period.

// File: rtl/flp_pkg.sv
package flp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_GAP
    } flp_state_e;
endpackage

// File: rtl/flp_tick_timer.sv
module flp_tick_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // A load of n makes the interval last n ticks: expired is seen on the nth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    assert_timer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/flp_word_shifter.sv
module flp_word_shifter #(
    parameter int N_BITS = 16,
    parameter int SW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              advance,
    input  logic [N_BITS-1:0] word_in,
    output logic              slot_bit,
    output logic              last_slot
);
    localparam int N_SLOTS = 2 * N_BITS + 1;

    logic [SW-1:0]     slot_q;
    logic [N_BITS-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            word_q <= '0;
        end else if (burst_start) begin
            slot_q <= '0;
            word_q <= word_in;
        end else if (advance) begin
            slot_q <= slot_q + SW'(1);
            if (slot_q[0]) begin
                word_q <= word_q >> 1;
            end
        end
    end

    // Even positions are clock pulses; odd positions take the current LSB.
    assign slot_bit  = slot_q[0] ? word_q[0] : 1'b1;
    assign last_slot = (slot_q == SW'(N_SLOTS - 1));

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SW'(N_SLOTS - 1));
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_start && !advance) |=> $stable(word_q));
endmodule

// File: rtl/flp_ctrl.sv
module flp_ctrl #(
    parameter int CW          = 18,
    parameter int PULSE_TICKS = 1,
    parameter int HALF_TICKS  = 625,
    parameter int GAP_TICKS   = 139375
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          stop,
    input  logic          timer_expired,
    input  logic          last_slot,
    input  logic          slot_bit,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output logic          burst_start,
    output logic          slot_advance,
    output logic          pulse_out,
    output logic          burst_done
);
    import flp_pkg::*;

    localparam logic [CW-1:0] MARK_LEN  = CW'(PULSE_TICKS);
    localparam logic [CW-1:0] SPACE_LEN = CW'(HALF_TICKS - PULSE_TICKS);
    localparam logic [CW-1:0] GAP_LEN   = CW'(GAP_TICKS);

    flp_state_e st_q, st_nxt;
    logic       run_q;
    logic       done_q;
    logic       finish;

    // Next-state and control decode
    always_comb begin
        st_nxt       = st_q;
        timer_load   = 1'b0;
        timer_val    = '0;
        burst_start  = 1'b0;
        slot_advance = 1'b0;
        finish       = 1'b0;
        if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (run_q) begin
                        st_nxt      = ST_MARK;
                        timer_load  = 1'b1;
                        timer_val   = MARK_LEN;
                        burst_start = 1'b1;
                    end
                end
                ST_MARK: begin
                    if (timer_expired) begin
                        st_nxt     = ST_SPACE;
                        timer_load = 1'b1;
                        timer_val  = SPACE_LEN;
                    end
                end
                ST_SPACE: begin
                    if (timer_expired) begin
                        if (last_slot) begin
                            finish = 1'b1;
                            if (run_q) begin
                                st_nxt     = ST_GAP;
                                timer_load = 1'b1;
                                timer_val  = GAP_LEN;
                            end else begin
                                st_nxt = ST_IDLE;
                            end
                        end else begin
                            st_nxt       = ST_MARK;
                            slot_advance = 1'b1;
                            timer_load   = 1'b1;
                            timer_val    = MARK_LEN;
                        end
                    end
                end
                ST_GAP: begin
                    if (!run_q) begin
                        st_nxt = ST_IDLE;
                    end else if (timer_expired) begin
                        st_nxt      = ST_MARK;
                        timer_load  = 1'b1;
                        timer_val   = MARK_LEN;
                        burst_start = 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            done_q <= finish;
            if (stop) begin
                run_q <= 1'b0;
            end else if (start) begin
                run_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        pulse_out  = (st_q == ST_MARK) && slot_bit;
        burst_done = done_q;
    end

    assert_first_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> pulse_out);
    assert_done_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);
    assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));
    assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !run_q);
endmodule

// File: rtl/flp_burst_tx.sv
module flp_burst_tx #(
    parameter int N_BITS      = 16,
    parameter int PULSE_TICKS = 1,
    parameter int HALF_TICKS  = 625,
    parameter int GAP_TICKS   = 139375
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              stop,
    input  logic [N_BITS-1:0] code_word,
    output logic              pulse_out,
    output logic              burst_done
);
    localparam int N_SLOTS = 2 * N_BITS + 1;
    localparam int SW      = $clog2(N_SLOTS);
    localparam int CW      = $clog2(GAP_TICKS + HALF_TICKS + 1);

    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          timer_expired;
    logic          burst_start;
    logic          slot_advance;
    logic          slot_bit;
    logic          last_slot;

    flp_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    flp_word_shifter #(.N_BITS(N_BITS), .SW(SW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .advance     (slot_advance),
        .word_in     (code_word),
        .slot_bit    (slot_bit),
        .last_slot   (last_slot)
    );

    flp_ctrl #(
        .CW          (CW),
        .PULSE_TICKS (PULSE_TICKS),
        .HALF_TICKS  (HALF_TICKS),
        .GAP_TICKS   (GAP_TICKS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .start         (start),
        .stop          (stop),
        .timer_expired (timer_expired),
        .last_slot     (last_slot),
        .slot_bit      (slot_bit),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .burst_start   (burst_start),
        .slot_advance  (slot_advance),
        .pulse_out     (pulse_out),
        .burst_done    (burst_done)
    );
endmodule

// File: tb/sim_flp_burst_tx.sv
module sim_flp_burst_tx;
    localparam int P = 2;
    localparam int H = 5;
    localparam int G = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] code_word = 16'h0001;
    logic        pulse_out;
    logic        burst_done;

    always #4 clk = ~clk;

    flp_burst_tx #(.N_BITS(16), .PULSE_TICKS(P), .HALF_TICKS(H), .GAP_TICKS(G)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
        .code_word(code_word), .pulse_out(pulse_out), .burst_done(burst_done)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Tick generator: one tick every tper cycles
    int tper = 1;
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1 >= tper) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // Behavioural reference model: phase 0 idle, 1 pulse window, 2 rest of position, 3 gap
    int          m_ph = 0, m_left = 0, m_slot = 0;
    logic [15:0] m_word = '0;
    bit          m_run = 0, m_done = 0, r;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_slot = 0; m_word = '0; m_run = 0; m_done = 0;
        end else begin
            r = m_run;
            m_done = 0;
            if (tick) begin
                case (m_ph)
                    0: if (r) begin m_ph = 1; m_left = P; m_slot = 0; m_word = code_word; end
                    1: if (m_left == 1) begin m_ph = 2; m_left = H - P; end else m_left--;
                    2: if (m_left == 1) begin
                           if (m_slot == 32) begin
                               m_done = 1;
                               if (r) begin m_ph = 3; m_left = G; end else m_ph = 0;
                           end else begin
                               m_slot++; m_ph = 1; m_left = P;
                           end
                       end else m_left--;
                    3: if (!r) m_ph = 0;
                       else if (m_left == 1) begin m_ph = 1; m_left = P; m_slot = 0; m_word = code_word; end
                       else m_left--;
                    default: m_ph = 0;
                endcase
            end
            if (stop) m_run = 0; else if (start) m_run = 1;
        end
    end

    function automatic bit exp_pulse();
        if (m_ph != 1) return 1'b0;
        if (m_slot % 2 == 0) return 1'b1;
        return m_word[(m_slot - 1) / 2];
    endfunction

    // Per-clock comparison, burst pulse count, done interval
    bit  prev_pulse = 0;
    int  pcount = 0;
    int  cyc = 0;
    int  last_done = -1;
    bit  chk_interval = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if (pulse_out !== exp_pulse()) begin
                fails++;
                $display("FAIL %s pulse_out at cycle %0d: actual %b expected %b", cur_req, cyc, pulse_out, exp_pulse());
            end
            checks++;
            if (burst_done !== m_done) begin
                fails++;
                $display("FAIL R5 burst_done at cycle %0d: actual %b expected %b", cyc, burst_done, m_done);
            end
            if (pulse_out && !prev_pulse) pcount++;
            if (burst_done) begin
                checks++;
                if (pcount != 17 + $countones(m_word)) begin
                    fails++;
                    $display("FAIL R2 R3 pulses per burst: actual %0d expected %0d", pcount, 17 + $countones(m_word));
                end
                pcount = 0;
                if (chk_interval && last_done >= 0) begin
                    checks++;
                    if (cyc - last_done != 33 * H + G) begin
                        fails++;
                        $display("FAIL R6 burst period: actual %0d expected %0d", cyc - last_done, 33 * H + G);
                    end
                end
                last_done = chk_interval ? cyc : -1;
            end
            prev_pulse = pulse_out;
        end else begin
            checks++;
            if (pulse_out !== 1'b0 || burst_done !== 1'b0) begin
                fails++;
                $display("FAIL R1 outputs in reset: actual %b%b expected 00", pulse_out, burst_done);
            end
        end
    end

    task automatic strobe(input bit s, input bit p);
        @(negedge clk); start = s; stop = p;
        @(negedge clk); start = 0; stop = 0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (burst_done) return;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset and idle before start
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);
        // R4/R6: main function, tick every cycle
        cur_req = "R4";
        code_word = 16'hA5C1;
        strobe(1, 0);
        wait_done(400);
        cur_req = "R6";
        chk_interval = 1;
        wait_done(400);
        wait_done(400);
        chk_interval = 0;
        // R8: stop mid-burst, burst completes then idle
        cur_req = "R8";
        repeat (40) @(negedge clk);
        strobe(0, 1);
        wait_done(400);
        repeat (300) @(negedge clk);
        // R7: word change mid-burst ignored
        cur_req = "R7";
        code_word = 16'h8001;
        strobe(1, 0);
        repeat (20) @(negedge clk);
        code_word = 16'h7FE1;
        wait_done(400);
        wait_done(400);
        // R8: stop during the gap
        cur_req = "R8";
        repeat (5) @(negedge clk);
        strobe(0, 1);
        repeat (300) @(negedge clk);
        // R10: slow tick
        cur_req = "R10";
        tper = 3;
        code_word = 16'h0001;
        strobe(1, 0);
        wait_done(1500);
        strobe(0, 1);
        wait_done(1500);
        repeat (50) @(negedge clk);
        tper = 1;
        // R9: simultaneous start and stop stays idle
        cur_req = "R9";
        strobe(1, 1);
        repeat (100) @(negedge clk);
        finish_run();
    end
endmodule